// File: doc/BRIEF.md
# Handshaked Host Register Port

This block is the slave side of an asynchronous microprocessor bus, run from the video clock. The host selects the block with an active-low chip select and starts a transfer with an active-low read or write strobe. The block answers with an active-low acknowledge. A read places data on the bus together with that acknowledge. The host must keep its strobe low until the acknowledge appears. The block then holds data and acknowledge until it has seen the strobe go high again.

Four direct registers are decoded from a two-bit address:
- 0 is the indirect pointer.
- 1 is the indirect data window onto an internal register file, addressed by the pointer. The pointer advances after every access through this window.
- 2 is the interrupt enable mask.
- 3 is the interrupt status.

Completion normally takes a few clocks. An internal readiness input can stretch a transfer, but a timeout caps every transfer at a fixed ceiling. After a read, the port refuses to start a new access for a short turnaround.

Top module: `hostreg_port`

## Requirements
- R1: After reset, `bus_ack_n` is 1, `bus_rdata_oe` is 0 and `irq` is 0.
- R2: With `stat_ready` high, `bus_ack_n` goes low at most 7 clocks after the strobe goes low while `bus_cs_n` is low.
- R3: With `stat_ready` high, read data is valid on `bus_rdata` no later than 4 clocks after the read strobe goes low, and it is valid in the first cycle that `bus_ack_n` is low.
- R4: While `stat_ready` is low, the acknowledge is delayed beyond the normal bound. Every access still completes within 52 clocks of its strobe. A rise of `stat_ready` during the wait ends the wait within 2 clocks.
- R5: A strobe released before the acknowledge does not abort the access. The acknowledge still arrives, and the access takes full effect, including the pointer advance.
- R6: `bus_ack_n` and `bus_rdata_oe` stay asserted for 3 clock samples after the strobe returns high. They are released on the 4th sample: 2 for synchronisation, 1 to detect the change, and 1 of hold.
- R7: After a read completes, no new access starts during the first 2 clocks back in the idle state. A write strobe that replaces the read strobe at its release therefore sees `bus_ack_n` high for at least 4 clock samples, and the write still takes effect.
- R8: Address 0 holds the indirect pointer, reading back zero-extended. Address 1 reads and writes the register-file entry at the pointer. Address 2 is the interrupt mask and address 3 the interrupt status.
- R9: Each access at address 1, read or write, increments the pointer by one, wrapping modulo 2^AW.
- R10: A pulse on `evt_in[i]` sets status bit i, and the bit stays set until cleared. Writing 1 to a status bit clears it and writing 0 leaves it. An event in the same clock as a clearing write leaves the bit set.
- R11: `irq` equals the OR of status AND mask, registered one clock after the status and mask.
- R12: `bus_rdata_oe` is high only while a read is acknowledged. It is low when idle and during write acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | video clock |
| rst | input | 1 | synchronous active-high reset |
| bus_cs_n | input | 1 | chip select, active low, asynchronous |
| bus_rd_n | input | 1 | read strobe, active low, asynchronous |
| bus_wr_n | input | 1 | write strobe, active low, asynchronous |
| bus_addr | input | 2 | direct register select |
| bus_wdata | input | DW | write data from host |
| bus_rdata | output | DW | read data to host |
| bus_rdata_oe | output | 1 | data bus output enable (high drives the bus) |
| bus_ack_n | output | 1 | transfer acknowledge, active low |
| stat_ready | input | 1 | internal readiness; low stretches transfers |
| evt_in | input | DW | interrupt event pulses, one per status bit |
| irq | output | 1 | interrupt request |

## Verification
The bench aims at the timing edges of the handshake. It measures the exact acknowledge latency with readiness high, with readiness low until the timeout, and with readiness rising in the middle of a wait. A design that counted the ceiling wrongly would acknowledge after 52 clocks or never. It drops the read strobe early while the port is stalled. A port that aborted on that drop would never acknowledge, and the pointer would not advance. It replaces a read strobe with a write strobe at the moment of release. A missing turnaround shows up as an acknowledge gap of only two samples. It also clears interrupt status in the same clock as a new event. A port where the clear beats the event would lose the bit.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam int ADR_W = 2;
  localparam logic [ADR_W-1:0] ADR_IPTR  = 2'd0;
  localparam logic [ADR_W-1:0] ADR_IDATA = 2'd1;
  localparam logic [ADR_W-1:0] ADR_MASK  = 2'd2;
  localparam logic [ADR_W-1:0] ADR_STAT  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_WAIT,
    ST_ACK,
    ST_RELEASE
  } hrp_state_e;
endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
  parameter int W = 3,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta[i] <= RST_VAL;
        q[i]    <= RST_VAL;
      end else begin
        meta[i] <= d[i];
        q[i]    <= meta[i];
      end
    end
  end
endmodule

// File: rtl/hrp_access_fsm.sv
module hrp_access_fsm
  import hrp_pkg::*;
#(
  parameter int MAX_LAT   = 52,
  parameter int TURN_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_s,
  input  logic       rd_s,
  input  logic       wr_s,
  input  logic       ready,
  output hrp_state_e st,
  output logic       is_rd,
  output logic       start,
  output logic       commit,
  output logic       ack_n,
  output logic       oe
);
  // 2 sync + 1 start + 1 decode + 1 commit edge are spent outside the wait
  localparam int WAIT_LIMIT = MAX_LAT - 5;
  localparam int CW = $clog2(WAIT_LIMIT + 1);
  localparam int GW = $clog2(TURN_CLKS + 1);

  logic [CW-1:0] wcnt;
  logic [GW-1:0] guard;
  logic          strobe_hi;
  hrp_state_e    nxt;

  assign start     = (st == ST_IDLE) && (guard == '0) && !cs_s && (!rd_s || !wr_s);
  assign commit    = ((st == ST_DECODE) && ready) ||
                     ((st == ST_WAIT) && (ready || (wcnt == CW'(WAIT_LIMIT))));
  assign strobe_hi = is_rd ? rd_s : wr_s;

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:    if (start) nxt = ST_DECODE;
      ST_DECODE:  nxt = commit ? ST_ACK : ST_WAIT;
      ST_WAIT:    if (commit) nxt = ST_ACK;
      ST_ACK:     if (strobe_hi) nxt = ST_RELEASE;
      ST_RELEASE: nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      is_rd <= 1'b0;
      wcnt  <= '0;
      guard <= '0;
      ack_n <= 1'b1;
      oe    <= 1'b0;
    end else begin
      st <= nxt;
      if (start) is_rd <= !rd_s;
      if (st == ST_DECODE) wcnt <= '0;
      else if ((st == ST_WAIT) && !commit) wcnt <= wcnt + CW'(1);
      if (st == ST_RELEASE) guard <= is_rd ? GW'(TURN_CLKS) : '0;
      else if (guard != '0) guard <= guard - GW'(1);
      if (commit) begin
        ack_n <= 1'b0;
        oe    <= is_rd;
      end else if (st == ST_RELEASE) begin
        ack_n <= 1'b1;
        oe    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hrp_regfile.sv
module hrp_regfile #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_wr,
  input  logic [AW-1:0] ptr_wdata,
  input  logic          dat_wr,
  input  logic          dat_acc,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] ptr,
  output logic [DW-1:0] rd_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (dat_wr) mem[ptr] <= wdata;
    rd_q <= mem[ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (ptr_wr) ptr <= ptr_wdata;
    else if (dat_acc) ptr <= ptr + AW'(1);
  end
endmodule

// File: rtl/hrp_irq.sv
module hrp_irq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] evt,
  input  logic          mask_wr,
  input  logic          stat_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] status,
  output logic          irq
);
  logic [DW-1:0] clr;

  assign clr = stat_wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask   <= '0;
      status <= '0;
      irq    <= 1'b0;
    end else begin
      if (mask_wr) mask <= wdata;
      status <= (status & ~clr) | evt;
      irq    <= |(status & mask);
    end
  end
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
  import hrp_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 4,
  parameter int MAX_LAT   = 52,
  parameter int TURN_CLKS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_cs_n,
  input  logic             bus_rd_n,
  input  logic             bus_wr_n,
  input  logic [ADR_W-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_rdata_oe,
  output logic             bus_ack_n,
  input  logic             stat_ready,
  input  logic [DW-1:0]    evt_in,
  output logic             irq
);
  logic [2:0]       strb_s;
  hrp_state_e       fsm_st;
  logic             acc_rd, acc_start, acc_commit;
  logic [ADR_W-1:0] addr_q;
  logic [DW-1:0]    wdata_q;
  logic [AW-1:0]    ptr;
  logic [DW-1:0]    rf_q, irq_mask, irq_status;
  logic             wr_ptr, wr_dat, wr_mask, wr_stat, dat_acc;

  hrp_sync #(.W(3), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_cs_n, bus_rd_n, bus_wr_n}),
    .q   (strb_s)
  );

  hrp_access_fsm #(.MAX_LAT(MAX_LAT), .TURN_CLKS(TURN_CLKS)) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .cs_s   (strb_s[2]),
    .rd_s   (strb_s[1]),
    .wr_s   (strb_s[0]),
    .ready  (stat_ready),
    .st     (fsm_st),
    .is_rd  (acc_rd),
    .start  (acc_start),
    .commit (acc_commit),
    .ack_n  (bus_ack_n),
    .oe     (bus_rdata_oe)
  );

  // address and data are held stable by the host across the access
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (acc_start) begin
      addr_q  <= bus_addr;
      wdata_q <= bus_wdata;
    end
  end

  assign wr_ptr  = acc_commit && !acc_rd && (addr_q == ADR_IPTR);
  assign wr_dat  = acc_commit && !acc_rd && (addr_q == ADR_IDATA);
  assign wr_mask = acc_commit && !acc_rd && (addr_q == ADR_MASK);
  assign wr_stat = acc_commit && !acc_rd && (addr_q == ADR_STAT);
  assign dat_acc = acc_commit && (addr_q == ADR_IDATA);

  hrp_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .ptr_wr    (wr_ptr),
    .ptr_wdata (wdata_q[AW-1:0]),
    .dat_wr    (wr_dat),
    .dat_acc   (dat_acc),
    .wdata     (wdata_q),
    .ptr       (ptr),
    .rd_q      (rf_q)
  );

  hrp_irq #(.DW(DW)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt_in),
    .mask_wr (wr_mask),
    .stat_wr (wr_stat),
    .wdata   (wdata_q),
    .mask    (irq_mask),
    .status  (irq_status),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (acc_commit && acc_rd) begin
      case (addr_q)
        ADR_IPTR:  bus_rdata <= {{(DW-AW){1'b0}}, ptr};
        ADR_IDATA: bus_rdata <= rf_q;
        ADR_MASK:  bus_rdata <= irq_mask;
        default:   bus_rdata <= irq_status;
      endcase
    end
  end
endmodule

// File: rtl/hostreg_port_chk.sv
module hostreg_port_chk
  import hrp_pkg::*;
#(
  parameter int DW      = 8,
  parameter int MAX_LAT = 52
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_ack_n,
  input logic          bus_rdata_oe,
  input logic          irq,
  input hrp_state_e    fsm_st,
  input logic          acc_rd,
  input logic [DW-1:0] irq_mask,
  input logic [DW-1:0] irq_status,
  input logic          wr_stat
);
  localparam int BW = $clog2(MAX_LAT + 2);
  logic [BW-1:0] busy;

  always_ff @(posedge clk) begin
    if (rst) busy <= '0;
    else if ((fsm_st == ST_DECODE) || (fsm_st == ST_WAIT)) busy <= busy + BW'(1);
    else busy <= '0;
  end

  a_r12_oe_only_in_ack: assert property (@(posedge clk) disable iff (rst)
    bus_rdata_oe |-> !bus_ack_n);

  a_r6_release_from_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ack_n) |-> ($past(fsm_st) == ST_RELEASE));

  a_r7_turn_first: assert property (@(posedge clk) disable iff (rst)
    ((fsm_st == ST_IDLE) && ($past(fsm_st) == ST_RELEASE) && $past(acc_rd)) |=> (fsm_st == ST_IDLE));

  a_r7_turn_second: assert property (@(posedge clk) disable iff (rst)
    ((fsm_st == ST_IDLE) && ($past(fsm_st) == ST_RELEASE) && $past(acc_rd)) |=> ##1 (fsm_st != ST_DECODE));

  a_r4_wait_bounded: assert property (@(posedge clk) disable iff (rst)
    (int'(busy) <= MAX_LAT - 3));

  a_r11_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (irq_mask == '0) |=> !irq);

  a_r10_status_sticky: assert property (@(posedge clk) disable iff (rst)
    !wr_stat |=> ((irq_status & $past(irq_status)) == $past(irq_status)));
endmodule

bind hostreg_port hostreg_port_chk #(.DW(DW), .MAX_LAT(MAX_LAT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_ack_n    (bus_ack_n),
  .bus_rdata_oe (bus_rdata_oe),
  .irq          (irq),
  .fsm_st       (fsm_st),
  .acc_rd       (acc_rd),
  .irq_mask     (irq_mask),
  .irq_status   (irq_status),
  .wr_stat      (wr_stat)
);

// File: tb/hostreg_port_tb.sv
module hostreg_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, evt_in = '0;
  logic       bus_rdata_oe, bus_ack_n, irq;
  logic       stat_ready = 1'b1;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       ack_prev = 1'b1;

  always #2 clk = ~clk;

  hostreg_port u_dut (
    .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe), .bus_ack_n(bus_ack_n),
    .stat_ready(stat_ready), .evt_in(evt_in), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares read data at each read acknowledge
  always @(negedge clk) begin
    if (!rst) begin
      if (ack_prev && !bus_ack_n && bus_rdata_oe) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected read", bus_rdata, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(bus_rdata == e, t, bus_rdata, e);
        end
      end
      ack_prev = bus_ack_n;
    end
  end

  task automatic release_chk(input string t);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!bus_ack_n, "R6 hold", bus_ack_n, 0);
    end
    @(negedge clk);
    chk(bus_ack_n && !bus_rdata_oe, {"R6 release / R12 ", t}, {bus_ack_n, bus_rdata_oe}, 2);
    repeat (2) @(negedge clk);
  endtask

  task automatic host_read(input logic [1:0] a, input logic [7:0] e, input string dtag,
                           input int lo, input int hi, input string ltag);
    int cnt = 0;
    exp_q.push_back(e);
    tag_q.push_back(dtag);
    @(negedge clk);
    bus_addr = a; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
    while (bus_ack_n && cnt < 64) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt >= lo && cnt <= hi, ltag, cnt, hi);
    chk(bus_rdata_oe, "R12 oe on read ack", bus_rdata_oe, 1);
    @(negedge clk);
    bus_rd_n = 1'b1; bus_cs_n = 1'b1;
    release_chk("read");
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d, input logic [7:0] ev);
    int cnt = 0;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
    while (bus_ack_n && cnt < 64) begin
      @(negedge clk);
      cnt++;
      if (cnt == 3 && ev != 0) evt_in = ev;
    end
    evt_in = '0;
    chk(cnt <= 7, "R2 write ack latency", cnt, 7);
    chk(!bus_rdata_oe, "R12 oe low on write", bus_rdata_oe, 0);
    @(negedge clk);
    bus_wr_n = 1'b1; bus_cs_n = 1'b1;
    release_chk("write");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_ack_n && !bus_rdata_oe && !irq, "R1 reset outputs",
        {bus_ack_n, bus_rdata_oe, irq}, 3'b100);

    // R8 / R9: indirect access through the pointer
    host_write(2'd0, 8'd2, 0);
    host_write(2'd1, 8'hA5, 0);
    host_write(2'd1, 8'h3C, 0);
    host_write(2'd0, 8'd2, 0);
    host_read(2'd1, 8'hA5, "R8 indirect data", 1, 4, "R3 data latency");
    host_read(2'd1, 8'h3C, "R9 pointer advanced", 1, 7, "R2 ack latency");
    host_read(2'd0, 8'h04, "R9 pointer value", 1, 7, "R2 ack latency");
    host_write(2'd0, 8'd15, 0);
    host_write(2'd1, 8'h77, 0);
    host_read(2'd0, 8'h00, "R9 pointer wrap", 1, 7, "R2 ack latency");

    // R5: early strobe release while stalled
    host_write(2'd0, 8'd5, 0);
    host_write(2'd1, 8'h11, 0);
    host_write(2'd0, 8'd5, 0);
    stat_ready = 1'b0;
    exp_q.push_back(8'h11);
    tag_q.push_back("R5 stalled read data");
    @(negedge clk);
    bus_addr = 2'd1; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
    repeat (2) @(negedge clk);
    bus_rd_n = 1'b1; bus_cs_n = 1'b1;
    begin
      int w = 0;
      while (bus_ack_n && w < 70) begin
        @(negedge clk);
        w++;
      end
      chk(!bus_ack_n, "R5 ack after early release", bus_ack_n, 0);
      while (!bus_ack_n && w < 80) begin
        @(negedge clk);
        w++;
      end
    end
    stat_ready = 1'b1;
    repeat (3) @(negedge clk);
    host_read(2'd0, 8'h06, "R5 access took effect", 1, 7, "R2 ack latency");

    // R4: stretched acknowledge, full timeout and early ready
    stat_ready = 1'b0;
    host_read(2'd0, 8'h06, "R4 timeout read data", 8, 52, "R4 timeout bound");
    fork
      host_read(2'd0, 8'h06, "R4 ready read data", 8, 12, "R4 ready ends wait");
      begin
        repeat (10) @(negedge clk);
        stat_ready = 1'b1;
      end
    join

    // R7: read strobe replaced by write strobe at release
    exp_q.push_back(8'h06);
    tag_q.push_back("R7 read before turnaround");
    @(negedge clk);
    bus_addr = 2'd0; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
    begin
      int w = 0;
      int hc = 1;
      while (bus_ack_n && w < 20) begin
        @(negedge clk);
        w++;
      end
      bus_rd_n = 1'b1; bus_wr_n = 1'b0; bus_addr = 2'd2; bus_wdata = 8'h0F;
      while (!bus_ack_n && w < 40) begin
        @(negedge clk);
        w++;
      end
      while (bus_ack_n && hc < 20) begin
        @(negedge clk);
        if (bus_ack_n) hc++;
      end
      chk(hc >= 4, "R7 turnaround gap", hc, 4);
    end
    @(negedge clk);
    bus_wr_n = 1'b1; bus_cs_n = 1'b1;
    repeat (6) @(negedge clk);
    host_read(2'd2, 8'h0F, "R7 write after turnaround", 1, 7, "R2 ack latency");

    // R10 / R11: interrupt status and request
    chk(!irq, "R11 irq idle", irq, 0);
    evt_in = 8'h12;
    @(negedge clk);
    evt_in = 8'h00;
    @(negedge clk);
    chk(irq, "R11 irq raised", irq, 1);
    host_read(2'd3, 8'h12, "R10 status set", 1, 7, "R2 ack latency");
    host_write(2'd3, 8'h02, 0);
    chk(!irq, "R11 irq after clear", irq, 0);
    host_read(2'd3, 8'h10, "R10 write-one-to-clear", 1, 7, "R2 ack latency");
    host_write(2'd3, 8'h10, 8'h10);
    host_read(2'd3, 8'h10, "R10 set wins over clear", 1, 7, "R2 ack latency");
    host_write(2'd3, 8'h10, 0);
    host_read(2'd3, 8'h00, "R10 cleared", 1, 7, "R2 ack latency");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule